// File: doc/BRIEF.md
# Partitioned Program/Data Memory Decoder

This block sits between an 8051-style core and its memory resources. Each cycle it takes one 16-bit address together with the kind of access: an instruction fetch, a data read or a data write. It decides whether the access goes to a shared nonvolatile RAM, to the external expansion bus or to a real-time-clock peripheral window. The routing depends on a mapping-mode bit. With the bit set, both the whole program space and the whole data space sit in RAM. With the bit clear, one RAM is split at a programmable boundary: program storage lies below the boundary and data lies above it.

The boundary comes from a partition register with 4 KB granularity. It may be rewritten at any time, and the next access uses the new value. Data writes that would land in the program area are blocked. Fetches that would have to leave the chip are refused. In both cases a fault pulse is raised. A peripheral-enable bit sends every data access to the clock window. All decoding is combinational, and the outputs are registered once so that they line up with the bus cycle that follows the request.

Top module: `part_mem_decoder`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every output is 0. Each output reflects the inputs sampled at the previous rising clock edge.
- R2: Access type 2'b00 (idle) produces no select, no write enable and no fault.
- R3: With map_full=1 and periph_en=0, a fetch (type 2'b01), a data read (2'b10) or a data write (2'b11) at any address asserts ram_ce. A data write also asserts ram_we.
- R4: With map_full=0, the boundary equals part_reg*4096. A fetch below the boundary asserts ram_ce and nothing else.
- R5: With map_full=0 and periph_en=0, a data access at or above the boundary, including exactly at the boundary, asserts ram_ce. A write there also asserts ram_we.
- R6: With map_full=0 and periph_en=0, a data read below the boundary asserts only ext_sel.
- R7: With map_full=0, a fetch at or above the boundary asserts no select and raises fault. A fetch never asserts ext_sel.
- R8: With map_full=0 and periph_en=0, a data write below the boundary asserts no select and no ram_we, and raises fault.
- R9: With periph_en=1, any data access asserts only rtc_sel, with no fault, in either mode. Fetches are decoded as if periph_en were 0.
- R10: A change of part_reg applies to the access presented in the same cycle as the new value.
- R11: At most one of ram_ce, ext_sel and rtc_sel is high. Fault never coincides with a select, and ram_we implies ram_ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Access address |
| acc_type | input | 2 | 00 idle, 01 fetch, 10 data read, 11 data write |
| part_reg | input | 4 | Partition boundary in 4 KB units |
| map_full | input | 1 | 1: whole spaces in RAM; 0: partitioned |
| periph_en | input | 1 | Route data accesses to the clock window |
| ram_ce | output | 1 | RAM chip enable |
| ext_sel | output | 1 | Expansion-bus select |
| rtc_sel | output | 1 | Clock-peripheral select |
| ram_we | output | 1 | RAM write enable |
| fault | output | 1 | One-cycle pulse for a blocked write or refused fetch |

## Verification
The block holds no state beyond one output register stage. A wrong decode therefore shows up at the ports in the very cycle after the offending request, as a wrong select, a missing or extra write enable, or a fault pulse with no cause. The bench predicts all five outputs for every request and compares them on every clock. Its stimulus leans on addresses one below, exactly at and above the boundary, on the zero and maximum partition values, and on a boundary that changes between back-to-back accesses.

// File: rtl/part_mem_decoder.sv
module part_mem_decoder #(
  parameter int ADDR_W = 16,
  parameter int PART_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc_type,
  input  logic [PART_W-1:0] part_reg,
  input  logic              map_full,
  input  logic              periph_en,
  output logic              ram_ce,
  output logic              ext_sel,
  output logic              rtc_sel,
  output logic              ram_we,
  output logic              fault
);
  localparam int GRAN_W = ADDR_W - PART_W;
  localparam logic [1:0] ACC_FETCH = 2'b01;
  localparam logic [1:0] ACC_READ  = 2'b10;
  localparam logic [1:0] ACC_WRITE = 2'b11;

  wire [ADDR_W-1:0] boundary = {part_reg, {GRAN_W{1'b0}}};
  wire below    = addr < boundary;
  wire is_fetch = acc_type == ACC_FETCH;
  wire is_data  = acc_type[1];
  wire is_wr    = acc_type == ACC_WRITE;

  wire fetch_ok  = is_fetch & (map_full | below);
  wire fetch_ref = is_fetch & ~fetch_ok;
  wire data_rtc  = is_data & periph_en;
  wire data_ram  = is_data & ~periph_en & (map_full | ~below);
  wire data_ext  = is_data & ~periph_en & ~map_full & below & ~is_wr;
  wire wr_block  = is_wr & ~periph_en & ~map_full & below;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_ce  <= 1'b0;
      ext_sel <= 1'b0;
      rtc_sel <= 1'b0;
      ram_we  <= 1'b0;
      fault   <= 1'b0;
    end else begin
      ram_ce  <= fetch_ok | data_ram;
      ext_sel <= data_ext;
      rtc_sel <= data_rtc;
      ram_we  <= is_wr & data_ram;
      fault   <= fetch_ref | wr_block;
    end
  end

  assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_ce, ext_sel, rtc_sel}));
  assert_fault_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(ram_ce || ext_sel || rtc_sel || ram_we));
  assert_we_needs_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_ce);
  assert_no_offchip_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type == ACC_FETCH |=> !ext_sel);
  assert_ext_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_type != ACC_READ) |=> !ext_sel);
  assert_rtc_when_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_type[1] && periph_en) |=> (rtc_sel && !fault));
  assert_full_never_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_full |=> !fault);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type == 2'b00 |=> !(ram_ce || ext_sel || rtc_sel || ram_we || fault));
  assert_read_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type == ACC_READ |=> !ram_we);
endmodule

// File: tb/test_part_mem_decoder.sv
`timescale 1ns/1ps
module test_part_mem_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0] acc_type = 2'b00;
  logic [3:0] part_reg = '0;
  logic map_full = 1'b1;
  logic periph_en = 1'b0;
  logic ram_ce, ext_sel, rtc_sel, ram_we, fault;

  int n_cmp = 0;
  int n_bad = 0;
  logic [4:0] exp_q = '0;
  string exp_tag = "R1";
  string tag_force = "";

  always #2 clk = ~clk;

  part_mem_decoder i_part_mem_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .acc_type(acc_type),
    .part_reg(part_reg), .map_full(map_full), .periph_en(periph_en),
    .ram_ce(ram_ce), .ext_sel(ext_sel), .rtc_sel(rtc_sel),
    .ram_we(ram_we), .fault(fault));

  // expected {ram_ce, ext_sel, rtc_sel, ram_we, fault}
  function automatic logic [4:0] model(input logic [1:0] t, input int a, input int p,
                                       input logic full, input logic pe, output string tag);
    int bnd = p * 4096;
    if (t == 2'b00) begin tag = "R2"; return 5'b00000; end
    if (t == 2'b01) begin
      if (full) begin tag = "R3"; return 5'b10000; end
      if (a < bnd) begin tag = "R4"; return 5'b10000; end
      tag = "R7"; return 5'b00001;
    end
    if (pe) begin tag = "R9"; return 5'b00100; end
    if (full) begin tag = "R3"; return (t == 2'b11) ? 5'b10010 : 5'b10000; end
    if (a >= bnd) begin tag = "R5"; return (t == 2'b11) ? 5'b10010 : 5'b10000; end
    if (t == 2'b10) begin tag = "R6"; return 5'b01000; end
    tag = "R8"; return 5'b00001;
  endfunction

  task automatic compare();
    logic [4:0] got = {ram_ce, ext_sel, rtc_sel, ram_we, fault};
    n_cmp++;
    if (got !== exp_q) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", exp_tag, got, exp_q);
    end
    n_cmp++;
    if (!$onehot0({ram_ce, ext_sel, rtc_sel}) || (fault && (ram_ce || ext_sel || rtc_sel))) begin
      n_bad++;
      $display("FAIL R11: outputs %b expected exclusive selects", got);
    end
  endtask

  task automatic step(input logic [1:0] t, input int a, input int p,
                      input logic full, input logic pe);
    string tg;
    @(negedge clk);
    compare();
    acc_type = t; addr = a[15:0]; part_reg = p[3:0]; map_full = full; periph_en = pe;
    exp_q = model(t, a, p, full, pe, tg);
    exp_tag = (tag_force != "") ? tag_force : tg;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state while reset is held with a busy request on the inputs
    acc_type = 2'b11; addr = 16'h1234;
    exp_q = 5'b0; exp_tag = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    acc_type = 2'b00;
    @(negedge clk); compare();
    rst_n = 1'b1;
    @(negedge clk); compare();

    step(2'b00, 16'h0000, 0, 1'b1, 1'b0);
    step(2'b00, 16'hFFFF, 5, 1'b0, 1'b0);
    step(2'b01, 16'hFFFF, 0, 1'b1, 1'b0);
    step(2'b10, 16'h1234, 0, 1'b1, 1'b0);
    step(2'b11, 16'h8000, 3, 1'b1, 1'b0);
    step(2'b01, 16'h4FFF, 5, 1'b0, 1'b0);
    step(2'b01, 16'h5000, 5, 1'b0, 1'b0);
    step(2'b10, 16'h5000, 5, 1'b0, 1'b0);
    step(2'b11, 16'h5000, 5, 1'b0, 1'b0);
    step(2'b11, 16'h4FFF, 5, 1'b0, 1'b0);
    step(2'b10, 16'h0000, 5, 1'b0, 1'b0);
    step(2'b10, 16'h4FFF, 5, 1'b0, 1'b0);
    step(2'b01, 16'h0000, 0, 1'b0, 1'b0);
    step(2'b11, 16'h0000, 0, 1'b0, 1'b0);
    step(2'b01, 16'hEFFF, 15, 1'b0, 1'b0);
    step(2'b01, 16'hF000, 15, 1'b0, 1'b0);
    step(2'b11, 16'hF000, 15, 1'b0, 1'b0);
    step(2'b11, 16'hEFFF, 15, 1'b0, 1'b0);
    // R10: boundary moves between back-to-back writes to the same address
    tag_force = "R10";
    step(2'b11, 16'h6000, 5, 1'b0, 1'b0);
    step(2'b11, 16'h6000, 8, 1'b0, 1'b0);
    step(2'b11, 16'h6000, 6, 1'b0, 1'b0);
    step(2'b01, 16'h6000, 7, 1'b0, 1'b0);
    tag_force = "";
    step(2'b10, 16'h0000, 5, 1'b0, 1'b1);
    step(2'b11, 16'h2000, 5, 1'b0, 1'b1);
    step(2'b11, 16'hC000, 0, 1'b1, 1'b1);
    step(2'b01, 16'h1000, 5, 1'b0, 1'b1);
    step(2'b01, 16'h9000, 5, 1'b0, 1'b1);
    for (int k = 0; k < 3000; k++) begin
      int a = $urandom_range(0, 65535);
      int p = $urandom_range(0, 15);
      if (k % 4 == 0) a = p * 4096 + $urandom_range(0, 2) - 1;
      if (a < 0) a = 0;
      if (a > 65535) a = 65535;
      step(2'($urandom_range(0, 3)), a, p, 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 4) == 0));
    end
    step(2'b00, 0, 0, 1'b0, 1'b0);
    @(negedge clk); compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule